// File: doc/BRIEF.md
# Key-Unlocked Watchdog Timer

A memory-mapped watchdog on a simple single-cycle register bus. It has three word locations: a control word, a timeout word and a key/service word. The control word holds the enable, a soft lock and a hard lock. When the soft lock is set, the control word cannot be changed. The only way to clear the soft lock is to write two fixed keys, in strict order, to the key word. Software writes the two keys and then polls the soft-lock bit until it reads clear before it reconfigures the watchdog.

Once enabled, a down-counter loads the programmed timeout and counts system clock cycles. When the count runs out, the watchdog raises a one-cycle reset request and starts the next period by itself. A second pair of keys, written in order while the watchdog runs, reloads the counter and so postpones the request.

The external reset is asynchronous and active-low. Its release is synchronised inside the block, so the block leaves reset on the third rising clock edge after `rst_n` goes high.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the control word (offset 0x0) and the timeout word (offset 0x4) read 0, `reset_req` is low, and both key sequencers expect their first key.
- R2: Writing 0x0000C520 and then 0x0000D928 to the key word (offset 0x8) clears the soft lock. Any other write to the key word in between, or either key alone or in the reverse order, leaves the lock set and returns the sequencer to expecting 0x0000C520.
- R3: The control word layout is bit 0 enable, bit 4 soft lock, bit 5 hard lock, and all other bits read 0. A write to the control word while the soft lock is set has no effect.
- R4: If the enable is set by a write accepted at clock edge E, `reset_req` is high during the cycle after edge E+T+1, where T is the timeout value. After that it pulses again every T+1 edges for as long as the watchdog stays enabled.
- R5: Each `reset_req` pulse lasts one cycle when T is nonzero. `reset_req` is never high while the watchdog is disabled, and clearing the enable stops all further pulses.
- R6: The timeout word accepts writes only while enable, soft lock and hard lock are all clear. Writes at any other time are ignored.
- R7: Writing 1 to control bit 4 while the configuration is open sets the soft lock again.
- R8: While enabled, writing 0x0000A602 and then 0x0000B480 to the key word reloads the counter at the edge E that accepts the second key. The next `reset_req` then follows at edge E+T+1.
- R9: A service pair that is out of order or interrupted does not reload the counter. Service keys written while the watchdog is disabled have no effect.
- R10: Once set, the hard lock blocks all control-word writes, all timeout writes and the unlock sequence until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the timeout counts its cycles |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset: 0x0 control, 0x4 timeout, 0x8 key/service |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data. Combinational. Zero when no read is selected or for the key word |
| reset_req | output | 1 | One-cycle request raised when the timeout expires |

## Verification
The bound checker checks these properties on every cycle: the sticky hard lock, the stability of the control and timeout words under each lock condition, that the soft lock clears only right after the second unlock key, and that it sets only from a control write. It also checks that requests never come from a disabled watchdog and never last two cycles. The bench's scenarios are the only place that shows the exact edge count from enable or service to each request. They also cover the key sequences broken in several ways, the periodic restart after expiry, and the return to the open state after reset once the hard lock has been set.

// File: rtl/wdt_key_pkg.sv
package wdt_key_pkg;

  // Byte offsets of the three register words
  localparam int OFF_CTRL = 'h0;
  localparam int OFF_TMO  = 'h4;
  localparam int OFF_KEY  = 'h8;

  // Control word bit positions
  localparam int BIT_EN  = 0;
  localparam int BIT_SLK = 4;
  localparam int BIT_HLK = 5;

  // Key values written to the key word
  localparam logic [31:0] UNLK_FIRST  = 32'h0000_C520;
  localparam logic [31:0] UNLK_SECOND = 32'h0000_D928;
  localparam logic [31:0] SRV_FIRST   = 32'h0000_A602;
  localparam logic [31:0] SRV_SECOND  = 32'h0000_B480;

  typedef enum logic {
    SEQ_WAIT_A = 1'b0,
    SEQ_WAIT_B = 1'b1
  } seq_st_e;

endpackage

// File: rtl/wdt_key_seq.sv
// Two-word ordered key detector: a hit fires on the second key only when it
// directly follows the first; any other write restarts the search.
module wdt_key_seq
  import wdt_key_pkg::*;
#(
  parameter int                 DATA_W = 32,
  parameter logic [DATA_W-1:0]  KEY_A  = '0,
  parameter logic [DATA_W-1:0]  KEY_B  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              arm,
  input  logic [DATA_W-1:0] wdata,
  output logic              hit
);

  seq_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    hit  = 1'b0;
    if (wr_stb) begin
      if (!arm) begin
        st_d = SEQ_WAIT_A;
      end else if (st_q == SEQ_WAIT_A) begin
        st_d = (wdata == KEY_A) ? SEQ_WAIT_B : SEQ_WAIT_A;
      end else begin
        hit  = (wdata == KEY_B);
        st_d = SEQ_WAIT_A;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEQ_WAIT_A;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/wdt_cfg_regs.sv
// Register decode, lock handling and read mux.
module wdt_cfg_regs
  import wdt_key_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wd_en,
  input  logic              wd_slk,
  input  logic              wd_hlk,
  input  logic [CNT_W-1:0]  wd_tmo,
  input  logic              unlock_hit,
  output logic              en_q,
  output logic              soft_q,
  output logic              hard_q,
  output logic [CNT_W-1:0]  to_q,
  output logic              key_wr,
  output logic              en_rise,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_TMO  = ADDR_W'(OFF_TMO);
  localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(OFF_KEY);
  localparam int                PAD_W  = DATA_W - CNT_W;

  logic             ctrl_wr, tmo_wr, cfg_open, tmo_open;
  logic             en_d, soft_d, hard_d;
  logic [CNT_W-1:0] to_d;
  logic [DATA_W-1:0] ctrl_view;

  always_comb begin
    ctrl_wr  = bus_sel && bus_wr && (bus_addr == A_CTRL);
    tmo_wr   = bus_sel && bus_wr && (bus_addr == A_TMO);
    key_wr   = bus_sel && bus_wr && (bus_addr == A_KEY);
    cfg_open = !soft_q && !hard_q;
    tmo_open = cfg_open && !en_q;
  end

  always_comb begin
    en_d    = en_q;
    soft_d  = soft_q;
    hard_d  = hard_q;
    to_d    = to_q;
    en_rise = 1'b0;
    if (ctrl_wr && cfg_open) begin
      en_d    = wd_en;
      soft_d  = wd_slk;
      hard_d  = wd_hlk;
      en_rise = wd_en && !en_q;
    end
    if (unlock_hit) soft_d = 1'b0;
    if (tmo_wr && tmo_open) to_d = wd_tmo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      soft_q <= 1'b0;
      hard_q <= 1'b0;
      to_q   <= '0;
    end else begin
      en_q   <= en_d;
      soft_q <= soft_d;
      hard_q <= hard_d;
      to_q   <= to_d;
    end
  end

  always_comb begin
    ctrl_view          = '0;
    ctrl_view[BIT_EN]  = en_q;
    ctrl_view[BIT_SLK] = soft_q;
    ctrl_view[BIT_HLK] = hard_q;
    bus_rdata          = '0;
    if (bus_sel && !bus_wr) begin
      if (bus_addr == A_CTRL)     bus_rdata = ctrl_view;
      else if (bus_addr == A_TMO) bus_rdata = {{PAD_W{1'b0}}, to_q};
    end
  end

endmodule

// File: rtl/wdt_down_cnt.sv
// Timeout counter: load wins, otherwise count down while enabled and
// raise a one-cycle request with automatic reload on reaching zero.
module wdt_down_cnt #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             req
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;

  always_comb begin
    cnt_d = cnt_q;
    req_d = 1'b0;
    if (load) begin
      cnt_d = load_val;
    end else if (en) begin
      if (cnt_q == '0) begin
        cnt_d = load_val;
        req_d = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign req = req_q;

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_key_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              reset_req
);

  logic [1:0]       rst_sync;
  logic             rst_s;
  logic             en_q, soft_q, hard_q, key_wr, en_rise;
  logic             unlock_hit, service_hit;
  logic [CNT_W-1:0] to_q;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  wdt_cfg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_s),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .wd_en     (bus_wdata[BIT_EN]),
    .wd_slk    (bus_wdata[BIT_SLK]),
    .wd_hlk    (bus_wdata[BIT_HLK]),
    .wd_tmo    (bus_wdata[CNT_W-1:0]),
    .unlock_hit(unlock_hit),
    .en_q      (en_q),
    .soft_q    (soft_q),
    .hard_q    (hard_q),
    .to_q      (to_q),
    .key_wr    (key_wr),
    .en_rise   (en_rise),
    .bus_rdata (bus_rdata)
  );

  wdt_key_seq #(
    .DATA_W(DATA_W),
    .KEY_A (DATA_W'(UNLK_FIRST)),
    .KEY_B (DATA_W'(UNLK_SECOND))
  ) u_unlock (
    .clk   (clk),
    .rst_n (rst_s),
    .wr_stb(key_wr),
    .arm   (!hard_q),
    .wdata (bus_wdata),
    .hit   (unlock_hit)
  );

  wdt_key_seq #(
    .DATA_W(DATA_W),
    .KEY_A (DATA_W'(SRV_FIRST)),
    .KEY_B (DATA_W'(SRV_SECOND))
  ) u_service (
    .clk   (clk),
    .rst_n (rst_s),
    .wr_stb(key_wr),
    .arm   (en_q),
    .wdata (bus_wdata),
    .hit   (service_hit)
  );

  wdt_down_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_s),
    .en      (en_q),
    .load    (en_rise || service_hit),
    .load_val(to_q),
    .req     (reset_req)
  );

endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk
  import wdt_key_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 24
) (
  input logic              clk,
  input logic              rst_s,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              en_q,
  input logic              soft_q,
  input logic              hard_q,
  input logic [CNT_W-1:0]  to_q,
  input logic              reset_req
);

  logic c_ctrl_wr, c_key_wr;
  assign c_ctrl_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
  assign c_key_wr  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_KEY));

  p_unlock_key_r2: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(soft_q) |-> $past(c_key_wr && bus_wdata == DATA_W'(UNLK_SECOND)));

  p_locked_ctrl_r3: assert property (@(posedge clk) disable iff (!rst_s)
    (c_ctrl_wr && (soft_q || hard_q)) |=> ($stable(en_q) && $stable(soft_q) && $stable(hard_q)));

  p_req_enabled_r5: assert property (@(posedge clk) disable iff (!rst_s)
    reset_req |-> $past(en_q));

  p_req_single_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (reset_req && to_q != '0) |=> !reset_req);

  p_tmo_guard_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (en_q || soft_q || hard_q) |=> $stable(to_q));

  p_soft_set_r7: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(soft_q) |-> $past(c_ctrl_wr && bus_wdata[BIT_SLK]));

  p_hard_sticky_r10: assert property (@(posedge clk) disable iff (!rst_s)
    hard_q |=> hard_q);

endmodule

bind keyed_wdt keyed_wdt_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_s    (rst_s),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .en_q     (en_q),
  .soft_q   (soft_q),
  .hard_q   (hard_q),
  .to_q     (to_q),
  .reset_req(reset_req)
);

// File: tb/sim_keyed_wdt.sv
`timescale 1ns/1ps
module sim_keyed_wdt;

  localparam int DW = 32;
  localparam int AW = 4;
  localparam int CW = 24;
  localparam int T  = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          reset_req;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int last_edge = 0;
  bit done = 0;

  always #2 clk = ~clk;

  keyed_wdt #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .reset_req(reset_req)
  );

  // ---------------- behavioural reference model ----------------
  int  m_rcnt = 0;
  bit  m_en = 0, m_soft = 0, m_hard = 0, m_req = 0;
  int  m_to = 0, m_cnt = 0;
  int  m_useq = 0, m_sseq = 0;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n || m_rcnt < 2) begin
      if (rst_n) m_rcnt = m_rcnt + 1; else m_rcnt = 0;
      m_en = 0; m_soft = 0; m_hard = 0; m_req = 0;
      m_to = 0; m_cnt = 0; m_useq = 0; m_sseq = 0;
    end else begin
      bit o_en, o_soft, o_hard, cw, tw, kw, u_hit, s_hit, ld;
      int o_to;
      o_en = m_en; o_soft = m_soft; o_hard = m_hard; o_to = m_to;
      cw = bus_sel && bus_wr && bus_addr == 0;
      tw = bus_sel && bus_wr && bus_addr == 4;
      kw = bus_sel && bus_wr && bus_addr == 8;
      u_hit = 0; s_hit = 0; ld = 0;
      if (kw) begin
        if (o_hard) m_useq = 0;
        else if (m_useq == 0) m_useq = (bus_wdata == 32'hC520) ? 1 : 0;
        else begin u_hit = (bus_wdata == 32'hD928); m_useq = 0; end
        if (!o_en) m_sseq = 0;
        else if (m_sseq == 0) m_sseq = (bus_wdata == 32'hA602) ? 1 : 0;
        else begin s_hit = (bus_wdata == 32'hB480); m_sseq = 0; end
      end
      if (cw && !o_soft && !o_hard) begin
        m_en = bus_wdata[0]; m_soft = bus_wdata[4]; m_hard = bus_wdata[5];
        ld = bus_wdata[0] && !o_en;
      end
      if (u_hit) m_soft = 0;
      if (tw && !o_en && !o_soft && !o_hard) m_to = int'(bus_wdata[CW-1:0]);
      if (ld || s_hit) begin m_cnt = o_to; m_req = 0; end
      else if (!o_en) m_req = 0;
      else if (m_cnt == 0) begin m_cnt = o_to; m_req = 1; end
      else begin m_cnt = m_cnt - 1; m_req = 0; end
    end
  end

  function automatic logic [DW-1:0] m_rd();
    logic [DW-1:0] v;
    v = '0;
    if (bus_sel && !bus_wr) begin
      if (bus_addr == 0) begin v[0] = m_en; v[4] = m_soft; v[5] = m_hard; end
      else if (bus_addr == 4) v = DW'(m_to);
    end
    return v;
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model (covers R4 R5 R8 R9 timing)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4/R5 model reset_req", {31'b0, reset_req}, {31'b0, m_req});
      chk("R3/R6 model rdata", bus_rdata, m_rd());
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input int addr, input logic [DW-1:0] data);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_addr = AW'(addr); bus_wdata = data;
    @(posedge clk); #1;
    last_edge = cyc;
    bus_sel = 0; bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(input int addr, input logic [DW-1:0] exp, input string tag);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 0; bus_addr = AW'(addr);
    @(negedge clk);
    chk(tag, bus_rdata, exp);
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic wait_req(output int at);
    at = -1;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (reset_req) begin at = cyc; break; end
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R_all actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    int e0, e1, e2, e3, e4;
    bit seen;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);

    rd(0, 32'h0, "R1 ctrl after reset");
    rd(4, 32'h0, "R1 timeout after reset");
    @(negedge clk); chk("R1 reset_req low", {31'b0, reset_req}, 32'h0);

    wr(4, T);
    rd(4, T, "R6 timeout write while open");

    wr(0, 32'h10);
    rd(0, 32'h10, "R7 soft lock set");
    wr(0, 32'h01);
    rd(0, 32'h10, "R3 ctrl write ignored while soft locked");
    wr(4, 55);
    rd(4, T, "R6 timeout write ignored while soft locked");

    wr(8, 32'hD928); wr(8, 32'hC520); wr(8, 32'hA602); wr(8, 32'hD928);
    rd(0, 32'h10, "R2 broken unlock keeps lock");
    wr(8, 32'hC520); wr(8, 32'hD928);
    rd(0, 32'h00, "R2 ordered keys clear lock");

    wr(0, 32'h01);
    e0 = last_edge;
    rd(0, 32'h01, "R3 enable write accepted when open");
    wait_req(e1);
    chk("R4 first expiry edge offset", e1 - e0, T + 1);
    @(negedge clk); chk("R5 request lasts one cycle", {31'b0, reset_req}, 32'h0);
    wait_req(e2);
    chk("R4 periodic expiry offset", e2 - e1, T + 1);

    repeat (6) @(negedge clk);
    wr(8, 32'hA602); wr(8, 32'hB480);
    e3 = last_edge;
    wait_req(e4);
    chk("R8 service reload offset", e4 - e3, T + 1);

    wr(8, 32'hB480); wr(8, 32'hA602); wr(8, 32'h1234);
    wr(4, 5);
    rd(4, T, "R6 timeout write ignored while enabled");
    wait_req(e1);
    chk("R9 bad service does not reload", e1 - e4, T + 1);

    wr(0, 32'h00);
    rd(0, 32'h00, "R5 enable cleared");
    wr(8, 32'hA602); wr(8, 32'hB480);
    seen = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (reset_req) seen = 1;
    end
    chk("R5/R9 no request while disabled", {31'b0, seen}, 32'h0);

    wr(0, 32'h21);
    rd(0, 32'h21, "R10 hard lock set");
    wr(0, 32'h00);
    rd(0, 32'h21, "R10 ctrl write blocked");
    wr(8, 32'hC520); wr(8, 32'hD928);
    wr(0, 32'h10);
    rd(0, 32'h21, "R10 unlock keys have no effect");
    wr(4, 7);
    rd(4, T, "R10 timeout write blocked");

    @(posedge clk); #1 rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    rd(0, 32'h0, "R10 hard lock cleared by reset");
    rd(4, 32'h0, "R1 timeout cleared by reset");

    repeat (2) @(posedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule